// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

This block is an 8-bit general-purpose output and input data port mapped into a 1 KB window of a 32-bit address space. Every address inside the window reaches the same data register. The address offset does not select a location. Instead, address bits [9:2] carry a per-bit mask, so software can set, clear or load any subset of the output pins in one bus write. No read-modify-write sequence is needed, so no other agent can interleave between the read and the write. To form the mask, software adds the offsets of the wanted bits: bit n has offset 4 << n. For example, 0x040 + 0x100 reaches bits 4 and 6 together.

Reads use the same mask. A read returns the synchronized pin inputs ANDed with the address mask, so bits outside the mask read as zero. The bus is a plain single-cycle target with no back-pressure:
- A write is taken on the clock edge where the write strobe is high.
- Read data is combinational while the read strobe is high.

An address outside the window is ignored.

Top module: `gpio_bitmask_port`

## Requirements
- R1: While `rst_n` is low, `pin_out` is 0x00. Reset is asynchronous and active low.
- R2: A write inside the window updates `pin_out[n]` to `wr_data[n]` only where address bit n+2 is 1. All other output bits keep their value. The change appears on the clock edge at which `wr_en` is sampled high.
- R3: A write whose address bits [9:2] are all zero (offset 0x000) leaves `pin_out` unchanged.
- R4: Address bits [1:0] have no effect on which bits a write or read reaches.
- R5: Write data bits [31:8] are ignored, and read data bits [31:8] are always zero.
- R6: While `rd_en` is high and the address is inside the window, `rd_data[n]` equals the synchronized `pin_in[n]` where address bit n+2 is 1, and 0 elsewhere.
- R7: A change on `pin_in` reaches the read path after exactly two rising clock edges. After one edge, reads still return the old value.
- R8: The window is hit only when address bits [31:10] equal those of `BASE_ADDR` (default 0x4000_5000). A write outside the window changes nothing, and a read outside it returns 0.
- R9: While `rd_en` is low, `rd_data` is 0.
- R10: A write and a read in the same cycle act independently. The read returns the synchronized pins from before the edge, and the write still updates `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Byte address; bits [9:2] are the bit mask |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data; bits [7:0] used |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Masked read data; zero when idle or outside the window |
| pin_out | output | 8 | Output pin register |
| pin_in | input | 8 | Asynchronous input pins |

## Verification
Two functions can fall in the same cycle: a masked write and a masked read aimed at the same window. The bench raises both strobes in one cycle, with a write value that differs from the pin inputs. It then judges the result in two places:
- Before the edge, the read data must show the synchronized pins under the mask and must not show the written value.
- After the edge, `pin_out` must hold the new value, while the read data still shows the pins.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_PINS    = 8;
  localparam int unsigned DEF_WIN_LOG = 10;
  localparam int unsigned DEF_SYNC    = 2;
  localparam logic [31:0] DEF_BASE    = 32'h4000_5000;
endpackage

// File: rtl/gpio_win_decode.sv
module gpio_win_decode #(
  parameter int unsigned ADDR_W  = gpio_mask_pkg::DEF_ADDR_W,
  parameter int unsigned PINS    = gpio_mask_pkg::DEF_PINS,
  parameter int unsigned WIN_LOG = gpio_mask_pkg::DEF_WIN_LOG,
  parameter logic [ADDR_W-1:0] BASE_ADDR = gpio_mask_pkg::DEF_BASE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              hit,
  output logic [PINS-1:0]   mask,
  output logic              wr_go,
  output logic              rd_go
);
  localparam int unsigned MASK_LSB = WIN_LOG - PINS;

  // window match on the bits above the 1 KB window
  assign hit   = (addr[ADDR_W-1:WIN_LOG] == BASE_ADDR[ADDR_W-1:WIN_LOG]);
  // the offset bits above the byte lanes form the pin mask
  assign mask  = addr[WIN_LOG-1:MASK_LSB];
  assign wr_go = wr_en && hit;
  assign rd_go = rd_en && hit;
endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
  parameter int unsigned PINS = gpio_mask_pkg::DEF_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_go,
  input  logic [PINS-1:0] mask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] q
);
  // per-bit update: each bit has its own enable taken from the mask
  for (genvar i = 0; i < PINS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q[i] <= 1'b0;
      else if (wr_go && mask[i]) q[i] <= wdata[i];
    end
  end

  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> ((q ^ $past(q)) & ~$past(mask)) == '0); // R2
  AST_MASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> ((q ^ $past(wdata)) & $past(mask)) == '0); // R2
  AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && mask == '0) |=> $stable(q)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(q)); // R2
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PINS   = gpio_mask_pkg::DEF_PINS,
  parameter int unsigned STAGES = gpio_mask_pkg::DEF_SYNC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] din,
  output logic [PINS-1:0] dout
);
  logic [PINS-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_bitmask_port.sv
module gpio_bitmask_port #(
  parameter int unsigned ADDR_W  = gpio_mask_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W  = gpio_mask_pkg::DEF_DATA_W,
  parameter int unsigned PINS    = gpio_mask_pkg::DEF_PINS,
  parameter int unsigned WIN_LOG = gpio_mask_pkg::DEF_WIN_LOG,
  parameter int unsigned SYNC    = gpio_mask_pkg::DEF_SYNC,
  parameter logic [ADDR_W-1:0] BASE_ADDR = gpio_mask_pkg::DEF_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [PINS-1:0]   pin_out,
  input  logic [PINS-1:0]   pin_in
);
  localparam int unsigned MASK_LSB = WIN_LOG - PINS;
  localparam int unsigned PAD_W    = DATA_W - PINS;

  logic            hit, wr_go, rd_go;
  logic [PINS-1:0] mask;
  logic [PINS-1:0] pins_q;

  gpio_win_decode #(
    .ADDR_W(ADDR_W), .PINS(PINS), .WIN_LOG(WIN_LOG), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .hit(hit), .mask(mask), .wr_go(wr_go), .rd_go(rd_go)
  );

  gpio_masked_reg #(.PINS(PINS)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .mask(mask),
    .wdata(wr_data[PINS-1:0]), .q(pin_out)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pins_q)
  );

  // masked read: unselected bits and the upper lanes read as zero
  always_comb begin
    rd_data = '0;
    if (rd_go) rd_data = {{PAD_W{1'b0}}, pins_q & mask};
  end

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(pin_out)); // R8
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:PINS] == '0); // R5
  AST_RD_UNMASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[PINS-1:0] & ~addr[WIN_LOG-1:MASK_LSB]) == '0); // R6
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0); // R9
endmodule

// File: tb/gpio_bitmask_port_test.sv
module gpio_bitmask_port_test;
  localparam logic [31:0] BASE = 32'h4000_5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  pin_out;
  logic [7:0]  pin_in = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bitmask_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_out(pin_out), .pin_in(pin_in)
  );

  // {offset[9:0], data[7:0], expected pin_out after the write}
  localparam logic [25:0] VEC [8] = '{
    {10'h3FC, 8'hA5, 8'hA5},   // R2 full mask load
    {10'h004, 8'h00, 8'hA4},   // R2 bit 0 clear
    {10'h140, 8'hFF, 8'hF4},   // R2 bits 4 and 6 set
    {10'h000, 8'h00, 8'hF4},   // R3 empty mask
    {10'h003, 8'h00, 8'hF4},   // R4 only low byte-lane bits
    {10'h207, 8'h00, 8'h74},   // R4 bits 7,0 with low bits set
    {10'h0C0, 8'h20, 8'h64},   // R2 bits 5,4 mixed
    {10'h3FC, 8'h3C, 8'h3C}    // R2 full reload
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] r);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2 r = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    #23;
    check("R1 reset", {24'h0, pin_out}, 32'h0);
    check("R9 idle in reset", rd_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      do_write(BASE + {22'h0, VEC[i][25:16]}, {24'hDEADBE, VEC[i][15:8]});
      check("R2/R3/R4/R5 table", {24'h0, pin_out}, {24'h0, VEC[i][7:0]});
    end

    // out-of-window write
    do_write(BASE + 32'h0000_07FC, 32'hFFFF_FF00);
    check("R8 miss write", {24'h0, pin_out}, 32'h0000_003C);
    do_write(BASE - 32'h4, 32'h0000_0000);
    check("R8 miss below", {24'h0, pin_out}, 32'h0000_003C);

    // masked reads
    pin_in = 8'hC3;
    repeat (3) @(negedge clk);
    do_read(BASE + 32'h3FC, r); check("R6 full read", r, 32'h0000_00C3);
    do_read(BASE + 32'h104, r); check("R6 bits 6,0", r, 32'h0000_0041);
    do_read(BASE + 32'h0F0, r); check("R6 bits 5..2", r, 32'h0000_0000);
    do_read(BASE + 32'h3FF, r); check("R4 read low bits", r, 32'h0000_00C3);
    do_read(BASE + 32'h000, r); check("R6 empty mask read", r, 32'h0);
    do_read(BASE + 32'h7FC, r); check("R8 miss read", r, 32'h0);
    @(negedge clk); addr = BASE + 32'h3FC; #2;
    check("R9 no strobe", rd_data, 32'h0);
    check("R5 upper zero", {24'h0, rd_data[31:8]} , 32'h0);

    // R7 synchronizer latency
    @(negedge clk); pin_in = 8'h3C; addr = BASE + 32'h3FC; rd_en = 1'b1;
    @(negedge clk); #2 check("R7 one edge old", rd_data, 32'h0000_00C3);
    @(negedge clk); #2 check("R7 two edges new", rd_data, 32'h0000_003C);
    rd_en = 1'b0;

    // R10 write and read in one cycle
    @(negedge clk);
    addr = BASE + 32'h3FC; wr_data = 32'h0000_0081; wr_en = 1'b1; rd_en = 1'b1;
    #2 check("R10 read before edge", rd_data, 32'h0000_003C);
    @(negedge clk);
    wr_en = 1'b0;
    #2 check("R10 write applied", {24'h0, pin_out}, 32'h0000_0081);
    check("R10 read still pins", rd_data, 32'h0000_003C);
    rd_en = 1'b0;

    // R1 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 check("R1 async reset", {24'h0, pin_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    do_write(BASE + 32'h200, 32'h80);
    check("R2 after reset", {24'h0, pin_out}, 32'h0000_0080);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule